// File: doc/BRIEF.md
# Reference frequency qualification monitor

This block decides whether one incoming reference clock runs close enough to its nominal rate to be trusted. The reference is assumed already brought into the local master clock domain as a one-cycle strobe per reference edge. The block counts those strobes over back-to-back gate windows of a fixed number of master clock cycles. It grades each window against one of two count bands. A wide band is used while the reference is trusted and a narrower one while it is not, which gives hysteresis. The out-of-range flag only moves once two windows in a row agree.

In parallel, every single reference period is timed in master clock cycles. A period far outside its allowed bounds, or one that differs too much from the period before it, disqualifies the reference at once. Such an event also throws away the window history and restarts the gate timer. The ppm-style limits are supplied as precomputed count bounds. For a primary and a secondary reference, two instances are used side by side.

Top module: `ref_qual_monitor`

## Requirements
- R1: While rst_n is low, and on the first edges after its release, out_of_range reads 1. Reset leaves the window history empty and holds no earlier reference period.
- R2: Each gate window spans GATE_CYCLES consecutive clock edges, beginning with the first edge after reset release, and windows follow back to back. A strobe is counted in the window that owns the edge sampling it. A window's verdict reaches out_of_range on the edge after the window's last edge.
- R3: While out_of_range is 0, a window fails if its strobe count is below fail_lo or above fail_hi. Otherwise it passes.
- R4: While out_of_range is 1, a window passes only if its count lies within pass_lo to pass_hi inclusive. Otherwise it fails.
- R5: Two consecutive failing windows set out_of_range, and two consecutive passing windows clear it. A single window that disagrees with its predecessor leaves the flag unchanged.
- R6: The period is the number of clock edges from one sampled strobe to the next. If it is below per_min or above per_max, out_of_range is 1 from edge E+1, where E is the edge that sampled the closing strobe, whatever the history.
- R7: If 100 times the absolute difference between a period and the period before it exceeds JUMP_PCT (default 30) times the earlier period, out_of_range is 1 from edge E+1.
- R8: A gross or jump fault empties the history and restarts the gate timer. The next window begins on edge E+2, so the flag can clear no earlier than edge E+2+2*GATE_CYCLES.
- R9: The first strobe after reset only starts period timing. The first complete period is checked against per_min and per_max but never against a previous period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_tick | input | 1 | One-cycle strobe per reference edge, master clock domain |
| fail_lo | input | WIN_W | Lowest window count still passing while trusted |
| fail_hi | input | WIN_W | Highest window count still passing while trusted |
| pass_lo | input | WIN_W | Lowest window count that requalifies |
| pass_hi | input | WIN_W | Highest window count that requalifies |
| per_min | input | PER_W | Shortest acceptable single period, in clock cycles |
| per_max | input | PER_W | Longest acceptable single period, in clock cycles |
| out_of_range | output | 1 | 1 while the reference is disqualified |

## Verification
A window's verdict is visible one edge after the window's last edge, at edge n*GATE_CYCLES+1 for the n-th window after reset. A fault period moves the flag one edge after the edge that sampled its closing strobe. After a fault, the earliest clear lands exactly 2*GATE_CYCLES+2 edges after that strobe edge. The bench drives strobes on a known edge grid and queues each expectation with the exact edge number it is due on. It samples on the falling edge following that rising edge. Around each timed event it checks the edge just before the change as well as the edge of the change, so both early and late responses are caught.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic {
    VERD_PASS = 1'b0,
    VERD_FAIL = 1'b1
  } rq_verdict_e;

  // Last window verdict, with a flag saying whether one exists yet.
  typedef struct packed {
    logic        valid;
    rq_verdict_e last;
  } rq_hist_t;

  localparam rq_hist_t RQ_HIST_EMPTY = '{valid: 1'b0, last: VERD_FAIL};

endpackage

// File: rtl/rq_gate_counter.sv
// Back-to-back gate windows of GATE_CYCLES edges; reports strobe count per window.
module rq_gate_counter #(
  parameter int GATE_CYCLES = 4096,
  parameter int WIN_W       = $clog2(GATE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  output logic             win_valid,
  output logic [WIN_W-1:0] win_count
);

  localparam int TMR_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(GATE_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [WIN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             last_edge;
  logic             valid_d;
  logic             count_en;

  always_comb begin
    last_edge = (tmr_q == TMR_LAST);
    cnt_inc   = cnt_q + WIN_W'(tick);
    count_en  = 1'b0;
    if (restart) begin
      tmr_d   = '0;
      cnt_d   = '0;
      valid_d = 1'b0;
    end else if (last_edge) begin
      tmr_d    = '0;
      cnt_d    = '0;
      valid_d  = 1'b1;
      count_en = 1'b1;
    end else begin
      tmr_d   = tmr_q + TMR_W'(1);
      cnt_d   = cnt_inc;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q     <= '0;
      cnt_q     <= '0;
      win_valid <= 1'b0;
      win_count <= '0;
    end else begin
      tmr_q     <= tmr_d;
      cnt_q     <= cnt_d;
      win_valid <= valid_d;
      if (count_en) begin
        win_count <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/rq_period_check.sv
// Times each reference period and flags gross or sudden changes at once.
module rq_period_check #(
  parameter int PER_W    = 12,
  parameter int JUMP_PCT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] per_min,
  input  logic [PER_W-1:0] per_max,
  output logic             impair
);

  localparam int PROD_W = PER_W + 7;
  localparam logic [PER_W-1:0] PER_SAT = '1;

  logic [PER_W-1:0]  per_q, per_d;
  logic [PER_W-1:0]  prev_q, prev_d;
  logic              seen_q, seen_d;
  logic              prev_ok_q, prev_ok_d;
  logic              impair_d;
  logic [PER_W-1:0]  delta;
  logic [PROD_W-1:0] delta_scaled, prev_scaled;
  logic              gross, jump;

  always_comb begin
    // per_q holds the edges since the last strobe, i.e. the period on a strobe
    if (tick) begin
      per_d = PER_W'(1);
    end else if (per_q != PER_SAT) begin
      per_d = per_q + PER_W'(1);
    end else begin
      per_d = per_q;
    end

    delta        = (per_q >= prev_q) ? (per_q - prev_q) : (prev_q - per_q);
    delta_scaled = PROD_W'(delta) * PROD_W'(100);
    prev_scaled  = PROD_W'(prev_q) * PROD_W'(JUMP_PCT);

    gross    = seen_q && ((per_q < per_min) || (per_q > per_max));
    jump     = prev_ok_q && (delta_scaled > prev_scaled);
    impair_d = tick && (gross || jump);

    seen_d    = seen_q;
    prev_d    = prev_q;
    prev_ok_d = prev_ok_q;
    if (tick) begin
      seen_d = 1'b1;
      if (seen_q) begin
        prev_d    = per_q;
        prev_ok_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q     <= '0;
      prev_q    <= '0;
      seen_q    <= 1'b0;
      prev_ok_q <= 1'b0;
      impair    <= 1'b0;
    end else begin
      per_q     <= per_d;
      prev_q    <= prev_d;
      seen_q    <= seen_d;
      prev_ok_q <= prev_ok_d;
      impair    <= impair_d;
    end
  end

endmodule

// File: rtl/rq_window_filter.sv
// Grades window counts with hysteresis and applies the two-in-a-row rule.
module rq_window_filter
  import rq_pkg::*;
#(
  parameter int WIN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [WIN_W-1:0] win_count,
  input  logic             impair,
  input  logic [WIN_W-1:0] fail_lo,
  input  logic [WIN_W-1:0] fail_hi,
  input  logic [WIN_W-1:0] pass_lo,
  input  logic [WIN_W-1:0] pass_hi,
  output logic             out_of_range
);

  rq_hist_t    hist_q, hist_d;
  logic        flag_d;
  logic        in_wide, in_narrow;
  rq_verdict_e verdict;

  always_comb begin
    in_wide   = (win_count >= fail_lo) && (win_count <= fail_hi);
    in_narrow = (win_count >= pass_lo) && (win_count <= pass_hi);
    if (out_of_range) begin
      verdict = in_narrow ? VERD_PASS : VERD_FAIL;
    end else begin
      verdict = in_wide ? VERD_PASS : VERD_FAIL;
    end

    flag_d = out_of_range;
    hist_d = hist_q;
    if (impair) begin
      flag_d = 1'b1;
      hist_d = RQ_HIST_EMPTY;
    end else if (win_valid) begin
      if (hist_q.valid && (hist_q.last == verdict)) begin
        flag_d = (verdict == VERD_FAIL);
      end
      hist_d = '{valid: 1'b1, last: verdict};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_of_range <= 1'b1;
      hist_q       <= RQ_HIST_EMPTY;
    end else begin
      out_of_range <= flag_d;
      hist_q       <= hist_d;
    end
  end

endmodule

// File: rtl/ref_qual_monitor.sv
// Frequency qualification of one reference strobe against the master clock.
module ref_qual_monitor #(
  parameter int GATE_CYCLES = 4096,
  parameter int WIN_W       = $clog2(GATE_CYCLES + 1),
  parameter int PER_W       = 12,
  parameter int JUMP_PCT    = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [WIN_W-1:0] fail_lo,
  input  logic [WIN_W-1:0] fail_hi,
  input  logic [WIN_W-1:0] pass_lo,
  input  logic [WIN_W-1:0] pass_hi,
  input  logic [PER_W-1:0] per_min,
  input  logic [PER_W-1:0] per_max,
  output logic             out_of_range
);

  logic             win_valid;
  logic [WIN_W-1:0] win_count;
  logic             impair;

  rq_period_check #(
    .PER_W    (PER_W),
    .JUMP_PCT (JUMP_PCT)
  ) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ref_tick),
    .per_min (per_min),
    .per_max (per_max),
    .impair  (impair)
  );

  rq_gate_counter #(
    .GATE_CYCLES (GATE_CYCLES),
    .WIN_W       (WIN_W)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ref_tick),
    .restart   (impair),
    .win_valid (win_valid),
    .win_count (win_count)
  );

  rq_window_filter #(
    .WIN_W (WIN_W)
  ) u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_valid    (win_valid),
    .win_count    (win_count),
    .impair       (impair),
    .fail_lo      (fail_lo),
    .fail_hi      (fail_hi),
    .pass_lo      (pass_lo),
    .pass_hi      (pass_hi),
    .out_of_range (out_of_range)
  );

endmodule

// File: rtl/ref_qual_monitor_chk.sv
module ref_qual_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic out_of_range,
  input logic win_valid,
  input logic impair
);

  // R1
  reset_flag_chk: assert property (@(posedge clk) !rst_n |-> out_of_range);

  // R6
  impair_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    impair |=> out_of_range);

  // R5
  flag_move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_of_range) |-> $past(win_valid || impair));

  // R5
  clear_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_of_range) |-> ($past(win_valid) && !$past(impair)));

  // R8
  restart_drops_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    impair |=> !win_valid);

  // R2
  one_verdict_per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> !win_valid);

endmodule

bind ref_qual_monitor ref_qual_monitor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_of_range (out_of_range),
  .win_valid    (win_valid),
  .impair       (impair)
);

// File: tb/ref_qual_monitor_test.sv
module ref_qual_monitor_test;

  localparam int G  = 220;
  localparam int WW = $clog2(G + 1);
  localparam int PW = 8;

  logic          clk;
  logic          rst_n;
  logic          ref_tick;
  logic [WW-1:0] fail_lo, fail_hi, pass_lo, pass_hi;
  logic [PW-1:0] per_min, per_max;
  logic          oor;

  ref_qual_monitor #(
    .GATE_CYCLES (G),
    .PER_W       (PW)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .fail_lo      (fail_lo),
    .fail_hi      (fail_hi),
    .pass_lo      (pass_lo),
    .pass_hi      (pass_hi),
    .per_min      (per_min),
    .per_max      (per_max),
    .out_of_range (oor)
  );

  typedef struct {
    int    at;
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    cyc      = 0;
  int    n_checks = 0;
  int    n_fail   = 0;
  int    since    = 0;
  bit    done     = 0;

  // 50 MHz: 20 time units per period
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // rising edges counted since reset release; edge k leaves cyc == k
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic compare(string tag, logic exp);
    n_checks++;
    if (oor !== exp) begin
      n_fail++;
      $display("FAIL %s: out_of_range=%b expected %b at edge %0d", tag, oor, exp, cyc);
    end
  endtask

  task automatic expect_at(int at, logic exp, string tag);
    item_t it;
    it.at  = at;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // set the strobe for the next rising edge, then wait past that edge
  task automatic edge_step(logic t);
    ref_tick = t;
    @(negedge clk);
  endtask

  task automatic run_edges(int p, int n);
    for (int i = 0; i < n; i++) begin
      since++;
      if (since >= p) begin
        since = 0;
        edge_step(1'b1);
      end else begin
        edge_step(1'b0);
      end
    end
  endtask

  task automatic run_ticks(int p, int nt);
    int got;
    got = 0;
    while (got < nt) begin
      since++;
      if (since >= p) begin
        since = 0;
        got++;
        edge_step(1'b1);
      end else begin
        edge_step(1'b0);
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  // monitor: pops expectations when their edge has been reached
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        item_t it;
        it = sb_q.pop_front();
        compare(it.tag, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2: watchdog expired, actual edge %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int a, t, b, j;
    rst_n    = 1'b1;
    ref_tick = 1'b0;
    fail_lo  = WW'(18);
    fail_hi  = WW'(23);
    pass_lo  = WW'(19);
    pass_hi  = WW'(21);
    per_min  = PW'(9);
    per_max  = PW'(14);
    #3 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    compare("R1 reset", 1'b1);

    // period 11 -> 20 per window, 10 -> 22, 13 -> 16 or 17
    expect_at(G + G/2,      1'b1, "R5 one pass only");
    expect_at(2*G,          1'b1, "R2 before verdict");
    expect_at(2*G + 1,      1'b0, "R2 R9 second pass clears");
    expect_at(2*G + G/2,    1'b0, "R5 cleared");
    expect_at(3*G + G/2,    1'b0, "R3 R5 single fail ignored");
    expect_at(5*G + G/2,    1'b0, "R3 R5 fail after pass ignored");
    expect_at(6*G + G/2,    1'b1, "R3 R5 two fails set");
    expect_at(8*G + G/2,    1'b1, "R4 count 22 cannot requalify");
    expect_at(10*G + G/2,   1'b0, "R4 R5 requalified");
    expect_at(12*G + G/2,   1'b0, "R3 count 22 passes while trusted");

    @(negedge clk);
    rst_n = 1'b1;
    since = 0;
    run_edges(11, 2*G);
    run_edges(13, G);
    run_edges(11, G);
    run_edges(13, 2*G);
    run_edges(10, 2*G);
    run_edges(11, 2*G);
    run_edges(10, 2*G);
    run_edges(11, 150);

    // gross short period at a+5, then jump back at t = a+16
    run_ticks(11, 1);
    a = cyc;
    expect_at(a + 5, 1'b0, "R6 not yet");
    expect_at(a + 6, 1'b1, "R6 short period");
    t = a + 16;
    expect_at(t + 1 + 2*G, 1'b1, "R8 history cleared");
    expect_at(t + 2 + 2*G, 1'b0, "R8 gate restarted");
    run_ticks(5, 1);
    run_edges(11, 2*G + 30);

    // sudden change 9 -> 12 inside the allowed bounds
    run_ticks(11, 1);
    b = cyc;
    j = b + 3*9 + 12;
    expect_at(j,     1'b0, "R7 not yet");
    expect_at(j + 1, 1'b1, "R7 period jump");
    run_ticks(9, 3);
    run_ticks(12, 1);
    run_edges(12, 20);

    if (sb_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2: %0d expectations unserved, expected 0", sb_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule